// File: doc/BRIEF.md
# Suspend Modulation Clock Throttler

This block slows a processor down by gating its core clock in bursts. It drives an active-low suspend output. The output alternates between a released phase, in which the processor runs, and an asserted phase, in which the processor core clock is stopped. Each phase length is a programmable 8-bit count of 32 µs ticks. The processor therefore runs at `run / (run + stop)` of its full rate, where run is the OFF count and stop is the ON count. The 32 µs tick comes from the system clock through a parameterised prescaler.

Software sets up the block through a byte-wide register port. Two speedup timers give back full speed for a while after an interrupt or after video activity. Each timer is reloaded by its event pulse, counts down in 1 ms units, and has its own enable bit. While either timer is nonzero the suspend output stays released. When both timers have run out, modulation resumes with a fresh OFF phase. A new phase count takes effect only at a phase boundary, so a write never cuts short the phase in progress.

Top module: `suspmod_throttle`

## Requirements
- R1: The register port holds six byte registers, all zero after reset, each read back through `cfg_rdata`:
  - power-management enable at 0x80;
  - interrupt speedup count at 0x8C;
  - video speedup count at 0x8D;
  - OFF count at 0x94;
  - ON count at 0x95;
  - suspend configuration at 0x96.

  A write to any other address changes nothing, and such an address reads 0.
- R2: During and right after reset `susp_n` is 1.
- R3: While bit 0 of the suspend configuration register is 0, `susp_n` is 1. Clearing the bit releases `susp_n` from the cycle after the write edge.
- R4: Setting bit 0 starts with a fresh OFF phase. `susp_n` stays 1 for OFF×TICK_DIV+1 cycles counted from the write edge.
- R5: In steady modulation `susp_n` is 0 for ON×TICK_DIV cycles and 1 for OFF×TICK_DIV cycles. Phases change only on a prescaler tick.
- R6: An ON count of 0 keeps `susp_n` at 1.
- R7: An OFF count of 0 with a nonzero ON count keeps `susp_n` at 0.
- R8: An OFF or ON count written mid-phase is first used at the next boundary that enters that phase. The phase in progress keeps its old length.
- R9: An `irq_evt` pulse takes effect when power-management enable bit 0 (global) and bit 3 (interrupt speedup) are both 1 and the interrupt count N is nonzero. It releases `susp_n` in the next cycle and holds it released for N×MS_DIV cycles. A fresh OFF phase then follows, so `susp_n` is 1 for N×MS_DIV+1+OFF×TICK_DIV cycles in total.
- R10: A repeated event while a speedup timer is running reloads that timer to its full count.
- R11: `vid_evt` behaves like R9, using bit 4 of the power-management enable register and the video count at 0x8D.
- R12: A speedup event has no effect on `susp_n` in any of these cases:
  - its own enable bit is 0;
  - the global bit is 0;
  - its count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| irq_evt | input | 1 | Interrupt activity pulse |
| vid_evt | input | 1 | Video activity pulse |
| susp_n | output | 1 | Active-low processor suspend |

## Verification
The assertions check four things on every cycle:
- `susp_n` stays released whenever modulation is disabled or a speedup timer is running;
- phases change only on a prescaler tick;
- ticks never come on back-to-back cycles;
- the output is released out of reset.

Some behaviour only the bench scenarios can show. These are the exact phase lengths across a sweep of OFF/ON pairs, and the extra cycle before the first OFF phase. They also include the deferred use of a count written mid-phase, and the length of a speedup hold including its retrigger. The cases where an event must be ignored are likewise covered by the scenarios only.

// File: rtl/sm_pkg.sv
// Shared constants of the suspend modulation throttler: register addresses
// and bit positions inside the control bytes.
package sm_pkg;
    localparam int BW = 8;

    localparam logic [BW-1:0] A_PME   = 8'h80;
    localparam logic [BW-1:0] A_IRQT  = 8'h8C;
    localparam logic [BW-1:0] A_VIDT  = 8'h8D;
    localparam logic [BW-1:0] A_OFF   = 8'h94;
    localparam logic [BW-1:0] A_ON    = 8'h95;
    localparam logic [BW-1:0] A_SCFG  = 8'h96;

    localparam int PME_GLOBAL = 0;
    localparam int PME_IRQ    = 3;
    localparam int PME_VID    = 4;
    localparam int SCFG_EN    = 0;

    localparam int NSPD = 2;
endpackage

// File: rtl/sm_regs.sv
// Byte register file of the throttler.
// Assumes one write per cycle. Reads are combinational from cfg_addr.
// Unmapped addresses ignore writes and read as zero.
module sm_regs
    import sm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [BW-1:0] addr,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] rdata,
    output logic [BW-1:0] pme,
    output logic [BW-1:0] irq_cnt,
    output logic [BW-1:0] vid_cnt,
    output logic [BW-1:0] off_cnt,
    output logic [BW-1:0] on_cnt,
    output logic [BW-1:0] scfg
);
    // Register update on a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pme     <= '0;
            irq_cnt <= '0;
            vid_cnt <= '0;
            off_cnt <= '0;
            on_cnt  <= '0;
            scfg    <= '0;
        end else if (we) begin
            case (addr)
                A_PME:   pme     <= wdata;
                A_IRQT:  irq_cnt <= wdata;
                A_VIDT:  vid_cnt <= wdata;
                A_OFF:   off_cnt <= wdata;
                A_ON:    on_cnt  <= wdata;
                A_SCFG:  scfg    <= wdata;
                default: ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        case (addr)
            A_PME:   rdata = pme;
            A_IRQT:  rdata = irq_cnt;
            A_VIDT:  rdata = vid_cnt;
            A_OFF:   rdata = off_cnt;
            A_ON:    rdata = on_cnt;
            A_SCFG:  rdata = scfg;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/sm_prescaler.sv
// Divides the system clock down to the phase tick.
// tick is a one-cycle pulse every DIV cycles while run is high.
// restart clears the divider so that the first tick comes DIV cycles later.
module sm_prescaler #(
    parameter int DIV = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Divider counter
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (run)
            cnt <= tick ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/sm_speedup.sv
// Retriggerable speedup timer counting down in units of MS_DIV clocks.
// A trigger loads the count and restarts the unit divider.
// busy is high while the remaining count is nonzero.
module sm_speedup #(
    parameter int MS_DIV = 50000,
    parameter int CW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic [CW-1:0] load,
    output logic          busy
);
    localparam int DW = (MS_DIV > 1) ? $clog2(MS_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(MS_DIV - 1);

    logic [CW-1:0] rem;
    logic [DW-1:0] div;

    assign busy = (rem != '0);

    // Reload on trigger, otherwise count down one unit per MS_DIV clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
            div <= '0;
        end else if (trig) begin
            rem <= load;
            div <= '0;
        end else if (busy) begin
            if (div == LAST) begin
                div <= '0;
                rem <= rem - 1'b1;
            end else begin
                div <= div + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sm_phase.sv
// OFF/ON phase sequencer.
// The counts are latched at start and at every phase boundary, so a phase in
// progress keeps its length. An ON count of zero keeps the OFF phase; an OFF
// count of zero with a nonzero ON count keeps the ON phase.
module sm_phase
    import sm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          tick,
    input  logic [BW-1:0] off_cnt,
    input  logic [BW-1:0] on_cnt,
    output logic          phase_on
);
    logic [BW-1:0] lat_off, lat_on, elapsed, len;
    logic          last;
    logic          nxt_on;

    assign len  = phase_on ? lat_on : lat_off;
    assign last = tick && ((len == '0) || (elapsed == len - 1'b1));

    // Next phase choice from the freshly latched counts
    always_comb begin
        if (phase_on)
            nxt_on = (off_cnt == '0) && (on_cnt != '0);
        else
            nxt_on = (on_cnt != '0);
    end

    // Phase state, latched counts and elapsed ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_on <= 1'b0;
            lat_off  <= '0;
            lat_on   <= '0;
            elapsed  <= '0;
        end else if (start) begin
            phase_on <= (off_cnt == '0) && (on_cnt != '0);
            lat_off  <= off_cnt;
            lat_on   <= on_cnt;
            elapsed  <= '0;
        end else if (last) begin
            phase_on <= nxt_on;
            lat_off  <= off_cnt;
            lat_on   <= on_cnt;
            elapsed  <= '0;
        end else if (tick) begin
            elapsed  <= elapsed + 1'b1;
        end
    end
endmodule

// File: rtl/suspmod_throttle.sv
// Top of the suspend modulation throttler.
// Modulation runs while the enable bit is set and no speedup timer is busy.
// Each rise of that condition restarts the prescaler and begins a fresh OFF
// phase. TICK_DIV is clocks per 32 us tick; MS_DIV is clocks per speedup unit.
module suspmod_throttle
    import sm_pkg::*;
#(
    parameter int TICK_DIV = 1600,
    parameter int MS_DIV   = 50000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [BW-1:0] cfg_addr,
    input  logic [BW-1:0] cfg_wdata,
    output logic [BW-1:0] cfg_rdata,
    input  logic          irq_evt,
    input  logic          vid_evt,
    output logic          susp_n
);
    logic [BW-1:0] pme, irq_cnt, vid_cnt, off_cnt, on_cnt, scfg;
    logic          mod_en, hold, run, run_q, start, tick, phase_on;

    logic [NSPD-1:0]         evt, en_bit, busy;
    logic [NSPD-1:0][BW-1:0] reload;

    sm_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .pme     (pme),
        .irq_cnt (irq_cnt),
        .vid_cnt (vid_cnt),
        .off_cnt (off_cnt),
        .on_cnt  (on_cnt),
        .scfg    (scfg)
    );

    assign evt    = {vid_evt, irq_evt};
    assign en_bit = {pme[PME_VID], pme[PME_IRQ]};
    assign reload = {vid_cnt, irq_cnt};

    for (genvar g = 0; g < NSPD; g++) begin : g_spd
        sm_speedup #(.MS_DIV(MS_DIV), .CW(BW)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .trig  (evt[g] && pme[PME_GLOBAL] && en_bit[g]),
            .load  (reload[g]),
            .busy  (busy[g])
        );
    end

    assign mod_en = scfg[SCFG_EN];
    assign hold   = |busy;
    assign run    = mod_en && !hold;
    assign start  = run && !run_q;

    // Remember whether modulation was running in the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run;
    end

    sm_prescaler #(.DIV(TICK_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .run     (run && run_q),
        .tick    (tick)
    );

    sm_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tick     (tick),
        .off_cnt  (off_cnt),
        .on_cnt   (on_cnt),
        .phase_on (phase_on)
    );

    assign susp_n = !(run && run_q && phase_on);
endmodule

// File: rtl/sm_checker.sv
// Cycle-level properties of the throttler, bound into the top module.
module sm_checker #(
    parameter int TICK_DIV = 1600
) (
    input logic clk,
    input logic rst_n,
    input logic susp_n,
    input logic mod_en,
    input logic hold,
    input logic tick,
    input logic run_q,
    input logic phase_on
);
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |-> susp_n);  // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> susp_n);  // R9

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> susp_n);  // R2

    AST_PHASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && (phase_on != $past(phase_on))) |-> $past(tick));  // R5

    if (TICK_DIV > 1) begin : g_spacing
        AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);  // R5
    end
endmodule

bind suspmod_throttle sm_checker #(.TICK_DIV(TICK_DIV)) u_chk (.*);

// File: tb/sim_suspmod_throttle.sv
// Self-checking bench: sweeps phase counts and speedup scenarios on a small
// configuration (4 clocks per tick, 5 clocks per speedup unit).
module sim_suspmod_throttle;
    localparam int D  = 4;
    localparam int MS = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       irq_evt = 1'b0;
    logic       vid_evt = 1'b0;
    logic       susp_n;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    suspmod_throttle #(.TICK_DIV(D), .MS_DIV(MS)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_evt(irq_evt),
        .vid_evt(vid_evt), .susp_n(susp_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // All tasks start and end at a negative clock edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic pulse(input bit vid);
        if (vid) vid_evt = 1'b1; else irq_evt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        vid_evt = 1'b0; irq_evt = 1'b0;
    endtask

    task automatic cnt_level(input logic lvl, output int n);
        n = 0;
        while (susp_n === lvl && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic setup(input logic [7:0] off, input logic [7:0] on);
        wr(8'h96, 8'h00);
        wr(8'h94, off);
        wr(8'h95, on);
        wr(8'h96, 8'h01);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n, errs;
        logic [7:0] d;
        int offs[4] = '{1, 2, 3, 7};
        int ons[3]  = '{1, 2, 5};
        logic [7:0] pmes[3] = '{8'h01, 8'h18, 8'h19};
        logic [7:0] icnt[3] = '{8'd3, 8'd3, 8'd0};
        logic [7:0] addrs[6] = '{8'h80, 8'h8C, 8'h8D, 8'h94, 8'h95, 8'h96};

        repeat (3) @(negedge clk);
        chk("R2 susp_n in reset", int'(susp_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 susp_n after reset", int'(susp_n), 1);

        // R1: reset values, readback, unmapped write
        foreach (addrs[i]) begin
            rd(addrs[i], d);
            chk("R1 reset value", int'(d), 0);
        end
        foreach (addrs[i]) begin
            wr(addrs[i], 8'h40 + 8'(i));
            rd(addrs[i], d);
            chk("R1 readback", int'(d), 'h40 + i);
        end
        wr(8'h90, 8'hFF);
        rd(8'h90, d);
        chk("R1 unmapped reads zero", int'(d), 0);
        rd(8'h94, d);
        chk("R1 unmapped write ignored", int'(d), 'h43);
        wr(8'h96, 8'h00);
        wr(8'h80, 8'h00);
        @(negedge clk);
        chk("R3 disabled idle", int'(susp_n), 1);

        // R4/R5 sweep of phase counts
        foreach (offs[i]) foreach (ons[j]) begin
            setup(8'(offs[i]), 8'(ons[j]));
            cnt_level(1'b1, n); chk("R4 first OFF", n, offs[i] * D + 1);
            cnt_level(1'b0, n); chk("R5 ON length", n, ons[j] * D);
            cnt_level(1'b1, n); chk("R5 OFF length", n, offs[i] * D);
            cnt_level(1'b0, n); chk("R5 ON repeat", n, ons[j] * D);
            wr(8'h96, 8'h00);
            chk("R3 disable releases", int'(susp_n), 1);
        end
        setup(8'd255, 8'd255);
        cnt_level(1'b1, n); chk("R4 first OFF max", n, 255 * D + 1);
        cnt_level(1'b0, n); chk("R5 ON max", n, 255 * D);

        // R6: ON count zero
        setup(8'd3, 8'd0);
        errs = 0;
        repeat (100) begin @(negedge clk); if (susp_n !== 1'b1) errs++; end
        chk("R6 never asserted", errs, 0);

        // R7: OFF count zero
        setup(8'd0, 8'd3);
        @(negedge clk);
        errs = 0;
        repeat (100) begin if (susp_n !== 1'b0) errs++; @(negedge clk); end
        chk("R7 always asserted", errs, 0);

        // R8: mid-phase write deferred to the next boundary
        setup(8'd2, 8'd3);
        cnt_level(1'b1, n);
        wr(8'h95, 8'd5);
        cnt_level(1'b0, n); chk("R8 current ON kept", n, 3 * D - 1);
        cnt_level(1'b1, n); chk("R8 OFF", n, 2 * D);
        cnt_level(1'b0, n); chk("R8 new ON used", n, 5 * D);

        // R9/R10: interrupt speedup
        wr(8'h96, 8'h00);
        wr(8'h80, 8'h19);
        wr(8'h8C, 8'd3);
        wr(8'h8D, 8'd2);
        setup(8'd2, 8'd4);
        cnt_level(1'b1, n);
        pulse(1'b0);
        chk("R9 released at once", int'(susp_n), 1);
        cnt_level(1'b1, n); chk("R9 hold + fresh OFF", n, 3 * MS + 1 + 2 * D);
        pulse(1'b0);
        repeat (9) @(negedge clk);
        chk("R10 still held", int'(susp_n), 1);
        pulse(1'b0);
        cnt_level(1'b1, n); chk("R10 retrigger reload", n, 3 * MS + 1 + 2 * D);

        // R11: video speedup only
        wr(8'h96, 8'h00);
        wr(8'h80, 8'h11);
        setup(8'd2, 8'd4);
        cnt_level(1'b1, n);
        pulse(1'b1);
        cnt_level(1'b1, n); chk("R11 video hold", n, 2 * MS + 1 + 2 * D);

        // R12: events ignored when disabled or zero count
        foreach (pmes[k]) begin
            wr(8'h96, 8'h00);
            wr(8'h80, pmes[k]);
            wr(8'h8C, icnt[k]);
            setup(8'd2, 8'd4);
            cnt_level(1'b1, n);
            pulse(1'b0);
            cnt_level(1'b0, n); chk("R12 event ignored", n, 4 * D - 1);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule